// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Offset Wrap Modes

This block is a synchronous binary counter made of several equal-width stages that share one clock. Each stage advances by a toggle rule. In each stage a bit flips when every lower bit of that stage equals 1 when counting up, or equals 0 when counting down. Each stage passes a ripple-carry signal to the enable of the stage above it. With the default parameters, two 4-bit stages form an 8-bit counter.

The counter has several controls:
- An active-low asynchronous reset.
- A synchronous clear.
- A synchronous parallel load.
- A count enable.
- A direction input.

A two-bit mode input picks the wrap behaviour. Plain binary counting wraps at the natural limits. Starting-offset counting restricts the range to a programmable start value up to all ones. Ending-offset counting restricts the range to zero up to a programmable end value.

The carry output marks the count that precedes a wrap while the counter is enabled. An outer counter can use it as its enable.

Top module: `updn_cascade_counter`

## Requirements
- R1: In binary mode (mode 00) with cnt_en=1, dir_down=0, no clear and no load, the count on the next clock edge is the old count plus 1, modulo 2^W.
- R2: In binary mode with cnt_en=1 and dir_down=1, the next count is the old count minus 1, modulo 2^W.
- R3: clr=1 makes the next count 0, whatever load, cnt_en and mode are.
- R4: load=1 with clr=0 makes the next count equal load_val, whatever cnt_en is and even at a wrap point.
- R5: With cnt_en=0, clr=0 and load=0, the count does not change.
- R6: carry_out is 1 exactly when cnt_en=1 and the count is at the wrap point of the current mode and direction. In binary mode that point is all ones when counting up and zero when counting down.
- R7: Each upper stage advances only when every lower stage carries. For example, 0x0F counts up to 0x10 and 0x10 counts down to 0x0F. In binary mode carry_out equals the carry of the top stage.
- R8: In starting-offset mode (mode 01), counting up from all ones loads start_val, and counting down from start_val loads all ones. Other values count by ±1.
- R9: In ending-offset mode (mode 10), counting up from end_val gives 0, and counting down from 0 gives end_val. Other values count by ±1.
- R10: Mode 11 behaves exactly as binary mode.
- R11: While rst_n=0 the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load |
| load_val | input | W (8) | Value taken on load |
| cnt_en | input | 1 | Count enable |
| dir_down | input | 1 | 1 = count down, 0 = count up |
| mode | input | 2 | 00/11 binary, 01 starting offset, 10 ending offset |
| start_val | input | W (8) | Low bound in starting-offset mode |
| end_val | input | W (8) | High bound in ending-offset mode |
| count | output | W (8) | Current count |
| carry_out | output | 1 | Enabled and at the wrap point |

## Verification
The in-line assertions watch several rules on every cycle:
- Clear to zero, load capture and hold when idle.
- ±1 steps in binary mode.
- Agreement between the top-stage ripple carry and the mode-level carry.
- The up-direction jumps in both offset modes.

The bench's reference model must show the rest. That covers the down-direction offset wraps, the crossings between stages at 0x0F/0x10, priority clashes such as load at a wrap point, and the equivalence of mode 11 with binary mode. The model compares every cycle of these scenarios.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

  typedef enum logic [1:0] {
    WRAP_BINARY     = 2'b00,
    WRAP_FROM_START = 2'b01,
    WRAP_AT_END     = 2'b10,
    WRAP_BINARY_ALT = 2'b11
  } wrap_mode_e;

endpackage

// File: rtl/updn_ctr_stage.sv
module updn_ctr_stage #(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               force_ld,
  input  logic [STAGE_W-1:0] force_val,
  input  logic               adv,
  input  logic               dir_down,
  output logic [STAGE_W-1:0] q,
  output logic               ripple
);

  // Bit i flips when all lower bits equal the "carry polarity":
  // 1 when counting up, 0 when counting down.
  function automatic logic [STAGE_W-1:0] toggle_mask(input logic [STAGE_W-1:0] v,
                                                     input logic down);
    logic [STAGE_W-1:0] m;
    logic run;
    run = 1'b1;
    for (int i = 0; i < STAGE_W; i++) begin
      m[i] = run;
      run  = run & (v[i] ^ down);
    end
    return m;
  endfunction

  logic [STAGE_W-1:0] q_next;
  logic               at_term;

  assign at_term = dir_down ? (q == '0) : (&q);
  assign ripple  = adv & at_term;

  always_comb begin
    if (clr)           q_next = '0;
    else if (force_ld) q_next = force_val;
    else if (adv)      q_next = q ^ toggle_mask(q, dir_down);
    else               q_next = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_stage_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  assert_stage_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !force_ld && !adv) |=> $stable(q));

  assert_stage_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !force_ld && adv && !dir_down) |=> (q == $past(q) + STAGE_W'(1)));

  assert_stage_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !force_ld && adv && dir_down) |=> (q == $past(q) - STAGE_W'(1)));

endmodule

// File: rtl/updn_ctr_wrap.sv
module updn_ctr_wrap
  import updn_ctr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] count,
  input  wrap_mode_e   mode,
  input  logic         dir_down,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] end_val,
  output logic         at_edge,
  output logic         offset_mode,
  output logic [W-1:0] wrap_val
);

  logic [W-1:0] edge_pt;

  always_comb begin
    unique case (mode)
      WRAP_FROM_START: begin
        edge_pt     = dir_down ? start_val : '1;
        wrap_val    = dir_down ? '1 : start_val;
        offset_mode = 1'b1;
      end
      WRAP_AT_END: begin
        edge_pt     = dir_down ? '0 : end_val;
        wrap_val    = dir_down ? end_val : '0;
        offset_mode = 1'b1;
      end
      default: begin
        edge_pt     = dir_down ? '0 : '1;
        wrap_val    = '0;
        offset_mode = 1'b0;
      end
    endcase
  end

  assign at_edge = (count == edge_pt);

endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_ctr_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       load,
  input  logic [STAGE_W*STAGES-1:0]  load_val,
  input  logic                       cnt_en,
  input  logic                       dir_down,
  input  logic [1:0]                 mode,
  input  logic [STAGE_W*STAGES-1:0]  start_val,
  input  logic [STAGE_W*STAGES-1:0]  end_val,
  output logic [STAGE_W*STAGES-1:0]  count,
  output logic                       carry_out
);

  localparam int W = STAGE_W * STAGES;

  wrap_mode_e   mode_e;
  logic         at_edge;
  logic         offset_mode;
  logic [W-1:0] wrap_val;
  logic         wrap_take;
  logic         force_ld;
  logic [W-1:0] force_val;
  logic [STAGES-1:0] stage_adv;
  logic [STAGES-1:0] stage_ripple;

  assign mode_e = wrap_mode_e'(mode);

  updn_ctr_wrap #(.W(W)) u_wrap (
    .count       (count),
    .mode        (mode_e),
    .dir_down    (dir_down),
    .start_val   (start_val),
    .end_val     (end_val),
    .at_edge     (at_edge),
    .offset_mode (offset_mode),
    .wrap_val    (wrap_val)
  );

  assign wrap_take = cnt_en & at_edge & offset_mode;
  assign force_ld  = load | wrap_take;
  assign force_val = load ? load_val : wrap_val;
  assign carry_out = cnt_en & at_edge;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_adv[g] = cnt_en;
    end else begin : g_chain
      assign stage_adv[g] = stage_ripple[g-1];
    end

    updn_ctr_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .force_ld  (force_ld),
      .force_val (force_val[g*STAGE_W +: STAGE_W]),
      .adv       (stage_adv[g]),
      .dir_down  (dir_down),
      .q         (count[g*STAGE_W +: STAGE_W]),
      .ripple    (stage_ripple[g])
    );
  end

  assert_load_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val)));

  assert_bin_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && !load && !offset_mode && !dir_down) |=> (count == $past(count) + W'(1)));

  assert_bin_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && !load && !offset_mode && dir_down) |=> (count == $past(count) - W'(1)));

  assert_top_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !offset_mode |-> (carry_out == stage_ripple[STAGES-1]));

  assert_start_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == WRAP_FROM_START && carry_out && !clr && !load && !dir_down)
      |=> (count == $past(start_val)));

  assert_end_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == WRAP_AT_END && carry_out && !clr && !load && !dir_down) |=> (count == '0));

endmodule

// File: tb/updn_cascade_counter_test.sv
`timescale 1ns/1ps
module updn_cascade_counter_test;

  localparam int W = 8;
  localparam logic [W-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, load = 1'b0, cnt_en = 1'b0, dir_down = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] load_val = '0, start_val = '0, end_val = '0;
  logic [W-1:0] count;
  logic carry_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] cnt;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  logic [W-1:0] ref_cnt = '0;

  updn_cascade_counter uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_val(load_val),
    .cnt_en(cnt_en), .dir_down(dir_down), .mode(mode), .start_val(start_val),
    .end_val(end_val), .count(count), .carry_out(carry_out)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cycles);
      summary();
    end
  end

  // Monitor: pops expected counts after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (count !== e.cnt) begin
        n_fails++;
        $display("FAIL %s: count actual %h expected %h", e.tag, count, e.cnt);
      end
    end
  end

  // Reference model of the wrap points and next state
  function automatic logic ref_edge(logic [W-1:0] c, logic [1:0] md, logic dn,
                                    logic [W-1:0] sv, logic [W-1:0] ev);
    if (md == 2'b01) return dn ? (c == sv) : (c == TOP);
    if (md == 2'b10) return dn ? (c == 0) : (c == ev);
    return dn ? (c == 0) : (c == TOP);
  endfunction

  function automatic logic [W-1:0] ref_next(logic [W-1:0] c, logic cl, logic ld,
      logic [W-1:0] lv, logic en, logic dn, logic [1:0] md, logic [W-1:0] sv, logic [W-1:0] ev);
    int v;
    if (cl) return '0;
    if (ld) return lv;
    if (!en) return c;
    if (md == 2'b01 && ref_edge(c, md, dn, sv, ev)) return dn ? TOP : sv;
    if (md == 2'b10 && ref_edge(c, md, dn, sv, ev)) return dn ? ev : '0;
    v = dn ? (int'(c) + 255) % 256 : (int'(c) + 1) % 256;
    return W'(v);
  endfunction

  // Driver: applies one cycle of stimulus, checks carry, queues expected count
  task automatic drive(logic cl, logic ld, logic [W-1:0] lv, logic en, logic dn,
                       logic [1:0] md, logic [W-1:0] sv, logic [W-1:0] ev, string tag);
    logic exp_c;
    exp_t e;
    @(negedge clk);
    clr = cl; load = ld; load_val = lv; cnt_en = en; dir_down = dn;
    mode = md; start_val = sv; end_val = ev;
    #1;
    exp_c = en && ref_edge(ref_cnt, md, dn, sv, ev);
    n_checks++;
    if (carry_out !== exp_c) begin
      n_fails++;
      $display("FAIL R6 (%s): carry_out actual %b expected %b", tag, carry_out, exp_c);
    end
    ref_cnt = ref_next(ref_cnt, cl, ld, lv, en, dn, md, sv, ev);
    e.cnt = ref_cnt; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run(int n, logic dn, logic [1:0] md, logic [W-1:0] sv,
                     logic [W-1:0] ev, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, '0, 1, dn, md, sv, ev, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (count !== '0) begin
      n_fails++;
      $display("FAIL R11: count actual %h expected 00", count);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1/R7 binary up crossing stage boundary 0x0F -> 0x10
    drive(0, 1, 8'h0D, 0, 0, 2'b00, 0, 0, "R4");
    run(5, 0, 2'b00, 0, 0, "R1 R7");
    // R1/R6 wrap FF -> 00 with carry
    drive(0, 1, 8'hFD, 0, 0, 2'b00, 0, 0, "R4");
    run(4, 0, 2'b00, 0, 0, "R1 R6");
    // R2 down through zero
    drive(0, 1, 8'h02, 0, 1, 2'b00, 0, 0, "R4");
    run(4, 1, 2'b00, 0, 0, "R2 R6");
    // R2/R7 down crossing 0x10 -> 0x0F
    drive(0, 1, 8'h11, 0, 1, 2'b00, 0, 0, "R4");
    run(3, 1, 2'b00, 0, 0, "R2 R7");
    // R5 hold
    for (int i = 0; i < 3; i++) drive(0, 0, 8'hAA, 0, 0, 2'b00, 0, 0, "R5");
    // R3 clear beats load and enable
    drive(1, 1, 8'h55, 1, 0, 2'b01, 8'h66, 0, "R3");
    // R4 load beats enable
    drive(0, 1, 8'h3C, 1, 1, 2'b00, 0, 0, "R4");
    // R8 starting offset, up and down
    drive(0, 1, 8'hFD, 0, 0, 2'b01, 8'h66, 0, "R4");
    run(6, 0, 2'b01, 8'h66, 0, "R8");
    drive(0, 1, 8'h68, 0, 1, 2'b01, 8'h66, 0, "R4");
    run(4, 1, 2'b01, 8'h66, 0, "R8");
    // R4 load wins at wrap point
    drive(0, 1, 8'hFF, 0, 0, 2'b01, 8'h66, 0, "R4");
    drive(0, 1, 8'h20, 1, 0, 2'b01, 8'h66, 0, "R4");
    // R9 ending offset, up and down
    drive(0, 1, 8'hD0, 0, 0, 2'b10, 0, 8'hD3, "R4");
    run(6, 0, 2'b10, 0, 8'hD3, "R9");
    drive(0, 1, 8'h02, 0, 1, 2'b10, 0, 8'hD3, "R4");
    run(4, 1, 2'b10, 0, 8'hD3, "R9");
    // R10 mode 11 as binary
    drive(0, 1, 8'hFE, 0, 0, 2'b11, 8'h40, 8'h40, "R4");
    run(3, 0, 2'b11, 8'h40, 8'h40, "R10");
    run(3, 1, 2'b11, 8'h40, 8'h40, "R10");
    // R3 clear in offset mode
    drive(1, 0, 0, 1, 1, 2'b10, 0, 8'hD3, "R3");
    drive(0, 0, 0, 0, 0, 2'b00, 0, 0, "R5");

    repeat (3) @(posedge clk);
    #2;
    summary();
  end

endmodule